// File: doc/BRIEF.md
# Processor Reset Vector Sequencer

This block governs how a small 8-bit processor core enters execution after power-up or after an external reset request. It watches an active-low reset request pin. It accepts a request only after the pin has been sampled low on two consecutive clock edges. When it sees the pin return high after such a request, it starts a fixed seven-cycle start-up sequence.

The first five cycles of the sequence are dummy reads from a fixed address. In the sixth and seventh cycles the block reads the two bytes of the start vector from the top of the address space, low byte first. An active-low vector-pull strobe is held low during those two reads. A ready input can stretch any cycle of the sequence, but it has no effect while the reset request is held low.

When the sequence ends, the block presents the assembled program counter and raises a one-cycle start-fetch pulse. In the same cycle it presents the status bits that hardware must force. The fetch logic downstream takes over from that point. A new reset request during the sequence abandons it at once.

Top module: `reset_vector_seq`

## Requirements
- R1: A release of `res_n` counts only after at least two consecutive clock edges that sampled it low. A release after a single low sample starts no sequence: `rd_en` and `start_fetch` stay 0 and `pc` keeps its value.
- R2: In every cycle that follows an edge sampling `res_n` low, `rd_en` is 0, `vec_pull_n` is 1 and `start_fetch` is 0, whatever `rdy` does.
- R3: The cycle after the edge that samples `res_n` high following a qualified low period is sequence cycle 1. With `rdy` high the sequence lasts exactly seven cycles, each with `rd_en` at 1.
- R4: Sequence cycles 1 to 5 read the dummy address 16'h01FF. `wr_en` is 0 throughout.
- R5: Cycle 6 reads address 16'hFFFC (vector low byte). Cycle 7 reads 16'hFFFD (vector high byte). The high-byte read never comes before the low-byte read.
- R6: `vec_pull_n` is 0 exactly in sequence cycles 6 and 7.
- R7: If `rdy` is 0 at the edge that ends a sequence cycle, that cycle repeats with the same address and no data is captured.
- R8: After cycle 7, `start_fetch` is 1 for exactly one cycle. In that cycle `pc` equals {byte read at 16'hFFFD, byte read at 16'hFFFC}.
- R9: During the `start_fetch` cycle, `status_val` is 8'h34 and `status_msk` is 8'h3C. In that value, bit 2 (interrupt disable) is 1, bit 3 (decimal mode) is 0, and bits 5 and 4 are 1. The other bits are left to software.
- R10: If `res_n` is sampled low during the sequence, the sequence is abandoned: the next cycle is idle and no start-fetch pulse follows.
- R11: Synchronous `rst` high puts the block in the idle state: `rd_en` 0, `vec_pull_n` 1, `start_fetch` 0, `pc` 0, `addr` 0.
- R12: `pc` changes only in a cycle where `start_fetch` is 1. An abandoned sequence leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| res_n | input | 1 | Active-low processor reset request |
| rdy | input | 1 | Ready; low stretches the current sequence cycle |
| rd_data | input | 8 | Read data returned for `addr` |
| addr | output | 16 | Address bus |
| rd_en | output | 1 | Read strobe |
| wr_en | output | 1 | Write strobe, held inactive |
| vec_pull_n | output | 1 | Active-low vector-read indicator |
| pc | output | 16 | Loaded program counter |
| start_fetch | output | 1 | One-cycle pulse handing over to normal fetch |
| status_val | output | 8 | Hardware-forced status bit values |
| status_msk | output | 8 | Marks which status bits are forced |

## Verification
On every cycle, the checker confirms several relations. Reset-low cycles leave the bus idle. The vector strobe appears only on a read. The high vector byte follows the low one. A stalled cycle repeats with the same address. The start-fetch pulse is single and follows the high-byte read. The program counter moves only on that pulse. The exact count of seven cycles, the dummy and vector addresses in each cycle, the rejection of a one-sample reset, the abort at each cycle and the assembled vector value can only be shown by the bench's scenarios. Those scenarios sweep low-period lengths, stall positions and abort positions.

// File: rtl/rvs_pkg.sv
package rvs_pkg;
  typedef enum logic [1:0] {
    ST_WAIT = 2'd0,
    ST_HELD = 2'd1,
    ST_SEQ  = 2'd2,
    ST_RUN  = 2'd3
  } rvs_state_t;

  localparam int STB_IRQ_OFF = 2;
  localparam int STB_DEC     = 3;
  localparam int STB_FOUR    = 4;
  localparam int STB_FIVE    = 5;
endpackage

// File: rtl/rvs_low_qual.sv
module rvs_low_qual #(
  parameter int MIN_LOW = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic res_n,
  output logic release_ok
);
  localparam int CW = $clog2(MIN_LOW + 1);

  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt <= '0;
    end else if (res_n) begin
      low_cnt <= '0;
    end else if (low_cnt != CW'(MIN_LOW)) begin
      low_cnt <= low_cnt + 1'b1;
    end
  end

  assign release_ok = res_n && (low_cnt == CW'(MIN_LOW));
endmodule

// File: rtl/rvs_ctrl.sv
module rvs_ctrl
  import rvs_pkg::*;
#(
  parameter int SEQ_LEN = 7,
  localparam int CW = $clog2(SEQ_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          res_n,
  input  logic          rdy,
  input  logic          release_ok,
  output rvs_state_t    state_n,
  output logic [CW-1:0] cyc_n,
  output logic          lo_cap,
  output logic          hi_cap,
  output logic          done
);
  rvs_state_t    state_q;
  logic [CW-1:0] cyc_q;
  logic          ret_q, ret_n;

  always_comb begin
    state_n = state_q;
    cyc_n   = cyc_q;
    ret_n   = ret_q;
    if (!res_n) begin
      state_n = ST_HELD;
      cyc_n   = '0;
      if (state_q != ST_HELD) ret_n = (state_q == ST_RUN);
    end else begin
      case (state_q)
        ST_HELD: begin
          if (release_ok) begin
            state_n = ST_SEQ;
            cyc_n   = CW'(1);
          end else begin
            state_n = ret_q ? ST_RUN : ST_WAIT;
          end
        end
        ST_SEQ: begin
          if (rdy) begin
            if (cyc_q == CW'(SEQ_LEN)) begin
              state_n = ST_RUN;
              cyc_n   = '0;
            end else begin
              cyc_n = cyc_q + 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_WAIT;
      cyc_q   <= '0;
      ret_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      cyc_q   <= cyc_n;
      ret_q   <= ret_n;
    end
  end

  logic advance;
  assign advance = (state_q == ST_SEQ) && res_n && rdy;
  assign lo_cap  = advance && (cyc_q == CW'(SEQ_LEN - 1));
  assign hi_cap  = advance && (cyc_q == CW'(SEQ_LEN));
  assign done    = hi_cap;
endmodule

// File: rtl/rvs_vec_cap.sv
module rvs_vec_cap #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              lo_cap,
  input  logic              hi_cap,
  output logic [2*DATA_W-1:0] pc
);
  logic [DATA_W-1:0] lo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= '0;
      pc   <= '0;
    end else begin
      if (lo_cap) lo_q <= rd_data;
      if (hi_cap) pc   <= {rd_data, lo_q};
    end
  end
endmodule

// File: rtl/reset_vector_seq.sv
module reset_vector_seq
  import rvs_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int SEQ_LEN = 7,
  parameter int MIN_LOW = 2,
  parameter logic [2*DATA_W-1:0] VEC_ADDR   = 16'hFFFC,
  parameter logic [2*DATA_W-1:0] DUMMY_ADDR = 16'h01FF
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                res_n,
  input  logic                rdy,
  input  logic [DATA_W-1:0]   rd_data,
  output logic [2*DATA_W-1:0] addr,
  output logic                rd_en,
  output logic                wr_en,
  output logic                vec_pull_n,
  output logic [2*DATA_W-1:0] pc,
  output logic                start_fetch,
  output logic [DATA_W-1:0]   status_val,
  output logic [DATA_W-1:0]   status_msk
);
  localparam int ADDR_W = 2 * DATA_W;
  localparam int CW     = $clog2(SEQ_LEN + 1);
  localparam logic [DATA_W-1:0] FORCE_MSK =
    DATA_W'((1 << STB_IRQ_OFF) | (1 << STB_DEC) | (1 << STB_FOUR) | (1 << STB_FIVE));
  localparam logic [DATA_W-1:0] FORCE_VAL =
    DATA_W'((1 << STB_IRQ_OFF) | (1 << STB_FOUR) | (1 << STB_FIVE));

  logic          release_ok;
  rvs_state_t    state_n;
  logic [CW-1:0] cyc_n;
  logic          lo_cap, hi_cap, done;

  rvs_low_qual #(.MIN_LOW(MIN_LOW)) u_qual (
    .clk(clk), .rst(rst), .res_n(res_n), .release_ok(release_ok)
  );

  rvs_ctrl #(.SEQ_LEN(SEQ_LEN)) u_ctrl (
    .clk(clk), .rst(rst), .res_n(res_n), .rdy(rdy), .release_ok(release_ok),
    .state_n(state_n), .cyc_n(cyc_n), .lo_cap(lo_cap), .hi_cap(hi_cap), .done(done)
  );

  rvs_vec_cap #(.DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst(rst), .rd_data(rd_data), .lo_cap(lo_cap), .hi_cap(hi_cap), .pc(pc)
  );

  logic              in_seq_n, vec_cyc_n;
  logic [ADDR_W-1:0] addr_sel;

  assign in_seq_n  = (state_n == ST_SEQ);
  assign vec_cyc_n = in_seq_n && (cyc_n >= CW'(SEQ_LEN - 1));

  always_comb begin
    if (cyc_n == CW'(SEQ_LEN))          addr_sel = VEC_ADDR + 1'b1;
    else if (cyc_n == CW'(SEQ_LEN - 1)) addr_sel = VEC_ADDR;
    else                                addr_sel = DUMMY_ADDR;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr        <= '0;
      rd_en       <= 1'b0;
      wr_en       <= 1'b0;
      vec_pull_n  <= 1'b1;
      start_fetch <= 1'b0;
      status_val  <= '0;
    end else begin
      addr        <= in_seq_n ? addr_sel : '0;
      rd_en       <= in_seq_n;
      wr_en       <= 1'b0;
      vec_pull_n  <= !vec_cyc_n;
      start_fetch <= done;
      status_val  <= done ? FORCE_VAL : '0;
    end
  end

  assign status_msk = FORCE_MSK;
endmodule

// File: rtl/reset_vector_seq_chk.sv
module reset_vector_seq_chk #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] VEC_ADDR = 16'hFFFC
) (
  input logic              clk,
  input logic              rst,
  input logic              res_n,
  input logic              rdy,
  input logic [ADDR_W-1:0] addr,
  input logic              rd_en,
  input logic              vec_pull_n,
  input logic [ADDR_W-1:0] pc,
  input logic              start_fetch
);
  localparam logic [ADDR_W-1:0] VEC_HI = VEC_ADDR + 1'b1;

  p_held_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !res_n |=> (!rd_en && vec_pull_n && !start_fetch));

  p_vecpull_on_read_r6: assert property (@(posedge clk) disable iff (rst)
    !vec_pull_n |-> rd_en);

  p_lo_before_hi_r5: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == VEC_HI) |->
      ($past(rd_en) && ($past(addr) == VEC_ADDR || $past(addr) == VEC_HI)));

  p_stall_repeat_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !rdy && res_n) |=> (rd_en && $stable(addr)));

  p_single_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    start_fetch |=> !start_fetch);

  p_pulse_after_hi_r8: assert property (@(posedge clk) disable iff (rst)
    start_fetch |-> ($past(addr) == VEC_HI && !$past(vec_pull_n)));

  p_pc_moves_on_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    !start_fetch |-> $stable(pc));
endmodule

bind reset_vector_seq reset_vector_seq_chk #(
  .ADDR_W(2 * DATA_W), .VEC_ADDR(VEC_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .res_n(res_n), .rdy(rdy), .addr(addr), .rd_en(rd_en),
  .vec_pull_n(vec_pull_n), .pc(pc), .start_fetch(start_fetch)
);

// File: tb/reset_vector_seq_bench.sv
module reset_vector_seq_bench;
  localparam int CLK_NS = 10;
  localparam logic [15:0] DUMMY = 16'h01FF;
  localparam logic [15:0] VLO   = 16'hFFFC;

  logic clk = 1'b0, rst = 1'b1, res_n = 1'b1, rdy = 1'b1;
  logic [7:0]  rd_data;
  logic [15:0] addr, pc;
  logic        rd_en, wr_en, vec_pull_n, start_fetch;
  logic [7:0]  status_val, status_msk;
  logic [15:0] vec_w = 16'h0000;
  logic [15:0] pc_cur = 16'h0000;
  int n_chk = 0, n_bad = 0;
  bit done_flag = 0;

  always #(CLK_NS / 2) clk = ~clk;

  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    if (a == VLO)               return vec_w[7:0];
    else if (a == VLO + 16'd1)  return vec_w[15:8];
    else                        return a[7:0] ^ 8'h5A;
  endfunction

  assign rd_data = mem_byte(addr);

  reset_vector_seq u_reset_vector_seq (
    .clk(clk), .rst(rst), .res_n(res_n), .rdy(rdy), .rd_data(rd_data),
    .addr(addr), .rd_en(rd_en), .wr_en(wr_en), .vec_pull_n(vec_pull_n),
    .pc(pc), .start_fetch(start_fetch), .status_val(status_val),
    .status_msk(status_msk)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic run(input int lowlen, input logic [15:0] v, input int stall_at,
                     input int abort_at);
    vec_w = v;
    res_n = 1'b0;
    for (int i = 0; i < lowlen; i++) begin
      rdy = i[0];
      step();
      chk("R2 rd_en while held", {31'd0, rd_en}, 32'd0);
      chk("R2 vec_pull_n while held", {31'd0, vec_pull_n}, 32'd1);
      chk("R2 start_fetch while held", {31'd0, start_fetch}, 32'd0);
    end
    rdy = 1'b1;
    res_n = 1'b1;
    if (lowlen < 2) begin
      for (int i = 0; i < 3; i++) begin
        step();
        chk("R1 short reset rd_en", {31'd0, rd_en}, 32'd0);
        chk("R1 short reset start_fetch", {31'd0, start_fetch}, 32'd0);
        chk("R1 short reset pc", {16'd0, pc}, {16'd0, pc_cur});
      end
      return;
    end
    for (int k = 1; k <= 7; k++) begin
      logic [15:0] ea;
      ea = (k == 6) ? VLO : (k == 7) ? VLO + 16'd1 : DUMMY;
      step();
      chk("R3 rd_en in sequence", {31'd0, rd_en}, 32'd1);
      chk((k <= 5) ? "R4 dummy address" : "R5 vector address", {16'd0, addr}, {16'd0, ea});
      chk("R4 wr_en", {31'd0, wr_en}, 32'd0);
      chk("R6 vec_pull_n", {31'd0, vec_pull_n}, (k >= 6) ? 32'd0 : 32'd1);
      if (k == abort_at) begin
        res_n = 1'b0;
        step();
        chk("R10 abort idles rd_en", {31'd0, rd_en}, 32'd0);
        chk("R10 abort vec_pull_n", {31'd0, vec_pull_n}, 32'd1);
        chk("R12 pc after abort", {16'd0, pc}, {16'd0, pc_cur});
        res_n = 1'b1;
        step();
        chk("R10 no pulse after abort", {31'd0, start_fetch}, 32'd0);
        chk("R10 no restart after one low", {31'd0, rd_en}, 32'd0);
        return;
      end
      if (k == stall_at) begin
        rdy = 1'b0;
        step();
        chk("R7 stalled cycle repeats address", {16'd0, addr}, {16'd0, ea});
        chk("R7 stalled cycle still reading", {31'd0, rd_en}, 32'd1);
        chk("R12 pc during stall", {16'd0, pc}, {16'd0, pc_cur});
        rdy = 1'b1;
      end
    end
    step();
    chk("R8 start_fetch pulse", {31'd0, start_fetch}, 32'd1);
    chk("R8 loaded pc", {16'd0, pc}, {16'd0, v});
    chk("R9 status value", {24'd0, status_val}, 32'h34);
    chk("R9 status mask", {24'd0, status_msk}, 32'h3C);
    chk("R3 sequence ended", {31'd0, rd_en}, 32'd0);
    pc_cur = v;
    step();
    chk("R8 pulse is one cycle", {31'd0, start_fetch}, 32'd0);
    chk("R12 pc held", {16'd0, pc}, {16'd0, pc_cur});
  endtask

  initial begin
    #(CLK_NS * 100000);
    if (!done_flag) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    repeat (3) step();
    rst = 1'b0;
    step();
    chk("R11 rd_en after rst", {31'd0, rd_en}, 32'd0);
    chk("R11 vec_pull_n after rst", {31'd0, vec_pull_n}, 32'd1);
    chk("R11 start_fetch after rst", {31'd0, start_fetch}, 32'd0);
    chk("R11 pc after rst", {16'd0, pc}, 32'd0);
    chk("R11 addr after rst", {16'd0, addr}, 32'd0);
    for (int lw = 1; lw <= 4; lw++) begin
      for (int st = 0; st <= 7; st++) begin
        logic [15:0] v;
        v = (16'(lw) * 16'h1357) ^ (16'(st) * 16'h0F21) ^ 16'hA5C3;
        run(lw, v, st, 0);
      end
    end
    for (int ab = 1; ab <= 7; ab++) begin
      run(3, 16'h2000 + 16'(ab) * 16'h0101, 0, ab);
      run(2, 16'hC000 ^ 16'(ab), ab, 0);
    end
    done_flag = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule